// File: doc/BRIEF.md
# Lockable Set-Associative Data Cache

This block is a data cache controller that sits between a processor load/store port and a word-wide memory port. Each set holds eight ways of eight 32-bit words (a 32-byte line). A request is held on the processor side until the block raises ready. Read hits and write-back store hits complete in the same cycle. Misses allocate a line: a dirty victim is first written back as an eight-word burst, and the new line is then filled as an eight-word burst.

Every store carries its own write-policy bit. A write-back store marks the line dirty. A write-through store updates the line only if it is already present, and always sends one word to memory. Replacement follows a per-set binary pseudo-LRU tree. A global 8-bit lock mask shields chosen ways from eviction in every set. When all eight ways are locked, a miss goes straight to memory without allocating. A single-cycle invalidate drops the whole contents, including any dirty data.

Top module: `lock_cache`

## Requirements
- R1: After reset every line is invalid, `mem_valid_o` and `req_ready_o` are low while no request is presented, and the first access to any line is a miss.
- R2: An allocating miss reads the line from memory as 8 words, starting at word 0 in ascending order (byte address step 4). It then completes with the word requested.
- R3: A read hit or a write-back store hit raises `req_ready_o` in the same cycle as the request, with no memory access. A read returns the most recently stored value for that address.
- R4: The victim is the lowest-index way that is invalid and unlocked. If there is none, the victim is the way the set's pseudo-LRU tree points to. If that way is locked, the victim is the lowest-index unlocked way.
- R5: If the victim is dirty, its 8 words are written to memory before the fill, at the victim's old line address, starting at word 0 in ascending order.
- R6: A write-through store that hits updates the cached word and performs exactly one memory write. The line stays clean.
- R7: A write-through store that misses performs exactly one memory write and allocates nothing.
- R8: The lock mask is loaded from `lock_i` when `lock_we_i` is high and applies to all sets. A locked way is never evicted, but it still serves hits.
- R9: With all 8 ways locked, a miss performs one single-word memory read or write at the request address and allocates nothing.
- R10: `inval_i` clears every valid and dirty bit and every tree in one cycle, with no writeback. Later accesses miss and see the memory contents.
- R11: Tree encoding per set: bit 0 selects the half (way bit 2); bit 1 or bit 2 (for half 0 or 1) selects the quarter (way bit 1); bit 3 plus the two-bit quarter number selects way bit 0. Every hit and every fill sets each bit on the accessed way's path to the inverse of that way's bit.
- R12: A write-back store that misses allocates the line like a read miss, then writes the word and marks the line dirty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| inval_i | input | 1 | Invalidate all lines, no writeback |
| lock_we_i | input | 1 | Load the lock mask |
| lock_i | input | 8 | New lock mask, one bit per way |
| req_valid_i | input | 1 | Processor request valid, held until ready |
| req_we_i | input | 1 | 1 = store, 0 = load |
| req_wt_i | input | 1 | Store policy: 1 = write-through, 0 = write-back |
| req_addr_i | input | 32 | Byte address (word aligned) |
| req_wdata_i | input | 32 | Store data |
| req_ready_o | output | 1 | Request completes this cycle |
| req_rdata_o | output | 32 | Load data, valid with ready |
| mem_valid_o | output | 1 | Memory transfer request |
| mem_we_o | output | 1 | Memory transfer is a write |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ready_i | input | 1 | Memory accepts the transfer; read data valid |
| mem_rdata_i | input | 32 | Memory read data |

## Verification
A reference model of tags, dirty bits, trees and the lock mask predicts, for each request, the hit/miss outcome, the counts of memory reads and writes, the writeback address and the returned data. The stimulus starts with a sweep that reads nine tags in every set, which fills the invalid ways in order and forces one tree-driven eviction per set. A second sweep of write-back stores then forces dirty writebacks, so the writeback address shows which way the tree and the lock fallback chose. Next come write-through sweeps that tell hit updates apart from non-allocating misses, and a long mixed sequence under changing lock masks that includes invalidation. Directed runs with one way locked and with all ways locked show that a locked line keeps hitting and that the bypass path allocates nothing.

// File: rtl/lc_pkg.sv
package lc_pkg;
  localparam int LC_WAYS = 8;
  localparam int LC_WW   = 3;

  typedef enum logic [1:0] {ST_IDLE, ST_WB, ST_FILL, ST_ONE} lc_state_e;

  // point every node on the path away from way w
  function automatic logic [6:0] plru_touch(input logic [6:0] t, input logic [2:0] w);
    logic [6:0] r;
    r = t;
    r[0] = ~w[2];
    if (w[2]) r[2] = ~w[1];
    else      r[1] = ~w[1];
    r[3'(w[2:1]) + 3'd3] = ~w[0];
    return r;
  endfunction
endpackage

// File: rtl/lc_data_ram.sv
module lc_data_ram #(
  parameter int DW = 32,
  parameter int AW = 10
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [2**AW];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/lc_tag_cmp.sv
module lc_tag_cmp #(
  parameter int TW   = 23,
  parameter int WAYS = 8,
  localparam int WW  = $clog2(WAYS)
) (
  input  logic [WAYS-1:0][TW-1:0] tags_i,
  input  logic [WAYS-1:0]         valid_i,
  input  logic [TW-1:0]           tag_i,
  output logic                    hit_o,
  output logic [WW-1:0]           way_o
);
  logic [WAYS-1:0] match;

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign match[g] = valid_i[g] && (tags_i[g] == tag_i);
  end

  always_comb begin
    way_o = '0;
    for (int i = WAYS - 1; i >= 0; i--) begin
      if (match[i]) way_o = WW'(i);
    end
  end

  assign hit_o = |match;
endmodule

// File: rtl/lc_victim.sv
module lc_victim
  import lc_pkg::*;
(
  input  logic [6:0]         tree_i,
  input  logic [LC_WAYS-1:0] valid_i,
  input  logic [LC_WAYS-1:0] lock_i,
  output logic [LC_WW-1:0]   way_o,
  output logic               none_o
);
  logic [LC_WAYS-1:0] free_w;
  logic [LC_WW-1:0]   walk_w, low_free, low_unl;
  logic               t0, t1;

  assign free_w = ~valid_i & ~lock_i;
  assign t0     = tree_i[0];
  assign t1     = t0 ? tree_i[2] : tree_i[1];
  assign walk_w = {t0, t1, tree_i[3'({t0, t1}) + 3'd3]};

  always_comb begin
    low_free = '0;
    low_unl  = '0;
    for (int i = LC_WAYS - 1; i >= 0; i--) begin
      if (free_w[i])  low_free = LC_WW'(i);
      if (!lock_i[i]) low_unl  = LC_WW'(i);
    end
  end

  always_comb begin
    if (|free_w)              way_o = low_free;
    else if (!lock_i[walk_w]) way_o = walk_w;
    else                      way_o = low_unl;
  end

  assign none_o = &lock_i;
endmodule

// File: rtl/lock_cache.sv
module lock_cache
  import lc_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int SETS  = 16,
  parameter int WORDS = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          inval_i,
  input  logic          lock_we_i,
  input  logic [7:0]    lock_i,
  input  logic          req_valid_i,
  input  logic          req_we_i,
  input  logic          req_wt_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          req_ready_o,
  output logic [DW-1:0] req_rdata_o,
  output logic          mem_valid_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic          mem_ready_i,
  input  logic [DW-1:0] mem_rdata_i
);
  localparam int IW  = $clog2(SETS);
  localparam int OW  = $clog2(WORDS);
  localparam int TW  = AW - IW - OW - 2;
  localparam int RAW = IW + LC_WW + OW;
  localparam logic [OW-1:0] LAST = OW'(WORDS - 1);

  logic [SETS-1:0][LC_WAYS-1:0][TW-1:0] tag_q;
  logic [SETS-1:0][LC_WAYS-1:0]         valid_q, dirty_q;
  logic [SETS-1:0][6:0]                 plru_q;
  logic [7:0]                           lock_q;
  lc_state_e                            state_q;
  logic [OW-1:0]                        cnt_q;
  logic [LC_WW-1:0]                     vict_q;

  logic [IW-1:0]    req_set;
  logic [OW-1:0]    req_off;
  logic [TW-1:0]    req_tag;
  logic             hit, none;
  logic [LC_WW-1:0] hit_way, vic_way;
  logic             ram_we;
  logic [RAW-1:0]   ram_waddr, ram_raddr;
  logic [DW-1:0]    ram_wdata, ram_rdata;

  assign req_set = req_addr_i[OW+2 +: IW];
  assign req_off = req_addr_i[2 +: OW];
  assign req_tag = req_addr_i[AW-1 -: TW];

  lc_tag_cmp #(.TW(TW), .WAYS(LC_WAYS)) u_cmp (
    .tags_i (tag_q[req_set]),
    .valid_i(valid_q[req_set]),
    .tag_i  (req_tag),
    .hit_o  (hit),
    .way_o  (hit_way)
  );

  lc_victim u_vic (
    .tree_i (plru_q[req_set]),
    .valid_i(valid_q[req_set]),
    .lock_i (lock_q),
    .way_o  (vic_way),
    .none_o (none)
  );

  lc_data_ram #(.DW(DW), .AW(RAW)) u_ram (
    .clk_i  (clk_i),
    .we_i   (ram_we),
    .waddr_i(ram_waddr),
    .wdata_i(ram_wdata),
    .raddr_i(ram_raddr),
    .rdata_o(ram_rdata)
  );

  always_comb begin
    req_ready_o = 1'b0;
    req_rdata_o = ram_rdata;
    mem_valid_o = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = req_addr_i;
    mem_wdata_o = req_wdata_i;
    ram_we      = 1'b0;
    ram_waddr   = {req_set, hit_way, req_off};
    ram_wdata   = req_wdata_i;
    ram_raddr   = {req_set, hit_way, req_off};
    unique case (state_q)
      ST_IDLE: if (req_valid_i && !inval_i && hit) begin
        req_ready_o = !(req_we_i && req_wt_i);
        ram_we      = req_we_i;
      end
      ST_ONE: begin
        mem_valid_o = 1'b1;
        mem_we_o    = req_we_i;
        req_ready_o = mem_ready_i;
        if (!req_we_i) req_rdata_o = mem_rdata_i;
      end
      ST_WB: begin
        mem_valid_o = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = {tag_q[req_set][vict_q], req_set, cnt_q, 2'b00};
        ram_raddr   = {req_set, vict_q, cnt_q};
        mem_wdata_o = ram_rdata;
      end
      ST_FILL: begin
        mem_valid_o = 1'b1;
        mem_addr_o  = {req_tag, req_set, cnt_q, 2'b00};
        ram_we      = mem_ready_i;
        ram_waddr   = {req_set, vict_q, cnt_q};
        ram_wdata   = mem_rdata_i;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
      plru_q  <= '0;
      lock_q  <= '0;
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      vict_q  <= '0;
    end else begin
      if (lock_we_i) lock_q <= lock_i;
      if (inval_i) begin
        valid_q <= '0;
        dirty_q <= '0;
        plru_q  <= '0;
        state_q <= ST_IDLE;
        cnt_q   <= '0;
      end else begin
        unique case (state_q)
          ST_IDLE: if (req_valid_i) begin
            if (hit) begin
              plru_q[req_set] <= plru_touch(plru_q[req_set], hit_way);
              if (req_we_i && !req_wt_i) dirty_q[req_set][hit_way] <= 1'b1;
              if (req_we_i && req_wt_i)  state_q <= ST_ONE;
            end else if ((req_we_i && req_wt_i) || none) begin
              state_q <= ST_ONE;
            end else begin
              vict_q  <= vic_way;
              cnt_q   <= '0;
              state_q <= dirty_q[req_set][vic_way] ? ST_WB : ST_FILL;
            end
          end
          ST_WB: if (mem_ready_i) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) state_q <= ST_FILL;
          end
          ST_FILL: if (mem_ready_i) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) begin
              valid_q[req_set][vict_q] <= 1'b1;
              dirty_q[req_set][vict_q] <= 1'b0;
              plru_q[req_set]          <= plru_touch(plru_q[req_set], vict_q);
              state_q                  <= ST_IDLE;
            end
          end
          ST_ONE: if (mem_ready_i) state_q <= ST_IDLE;
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (state_q == ST_FILL && mem_ready_i && cnt_q == LAST && !inval_i)
      tag_q[req_set][vict_q] <= req_tag;
  end
endmodule

// File: rtl/lc_checker.sv
module lc_checker
  import lc_pkg::*;
#(
  parameter int AW = 32,
  parameter int OW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          inval_i,
  input logic          req_valid_i,
  input logic          req_ready_o,
  input logic          mem_valid_o,
  input logic          mem_we_o,
  input logic          mem_ready_i,
  input logic [AW-1:0] mem_addr_o,
  input lc_state_e     state_q,
  input logic [OW-1:0] cnt_q,
  input logic [2:0]    vict_q,
  input logic [7:0]    lock_q
);
  localparam logic [OW-1:0] LAST = '1;

  assert_ready_needs_req_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> req_valid_i);

  assert_mem_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_valid_i && state_q == ST_IDLE) |-> !mem_valid_o);

  assert_fill_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FILL && mem_ready_i && cnt_q != LAST && !inval_i)
      |=> (mem_valid_o && !mem_we_o && mem_addr_o == $past(mem_addr_o) + AW'(4)));

  assert_wb_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WB && mem_ready_i && cnt_q != LAST && !inval_i)
      |=> (mem_valid_o && mem_we_o && mem_addr_o == $past(mem_addr_o) + AW'(4)));

  assert_victim_unlocked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FILL) |-> !lock_q[vict_q]);

  assert_no_hit_after_inval_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inval_i |=> !(state_q == ST_IDLE && req_ready_o));
endmodule

bind lock_cache lc_checker #(.AW(AW), .OW(OW)) u_lc_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .inval_i    (inval_i),
  .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o),
  .mem_valid_o(mem_valid_o),
  .mem_we_o   (mem_we_o),
  .mem_ready_i(mem_ready_i),
  .mem_addr_o (mem_addr_o),
  .state_q    (state_q),
  .cnt_q      (cnt_q),
  .vict_q     (vict_q),
  .lock_q     (lock_q)
);

// File: tb/lock_cache_bench.sv
module lock_cache_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        inval_i = 1'b0, lock_we_i = 1'b0;
  logic [7:0]  lock_i = '0;
  logic        req_valid_i = 1'b0, req_we_i = 1'b0, req_wt_i = 1'b0;
  logic [31:0] req_addr_i = '0, req_wdata_i = '0;
  logic        req_ready_o, mem_valid_o, mem_we_o, mem_ready_i;
  logic [31:0] req_rdata_o, mem_addr_o, mem_wdata_o, mem_rdata_i;

  always #10 clk_i = ~clk_i;

  lock_cache u_lock_cache (
    .clk_i(clk_i), .rst_ni(rst_ni), .inval_i(inval_i), .lock_we_i(lock_we_i), .lock_i(lock_i),
    .req_valid_i(req_valid_i), .req_we_i(req_we_i), .req_wt_i(req_wt_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i),
    .req_ready_o(req_ready_o), .req_rdata_o(req_rdata_o),
    .mem_valid_o(mem_valid_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_ready_i(mem_ready_i), .mem_rdata_i(mem_rdata_i)
  );

  logic [31:0] bench_mem [2048];
  logic [31:0] gold [2048];
  assign mem_ready_i = mem_valid_o;
  assign mem_rdata_i = bench_mem[mem_addr_o[12:2]];

  int checks = 0, fails = 0;
  int mon_rd, mon_wr;
  logic [31:0] first_wr, last_wr, last_rd;
  bit rd_seq_ok, wr_seq_ok;

  always @(posedge clk_i) begin
    if (rst_ni && mem_valid_o && mem_ready_i) begin
      if (mem_we_o) begin
        bench_mem[mem_addr_o[12:2]] = mem_wdata_o;
        if (mon_wr == 0) begin
          first_wr  = mem_addr_o;
          wr_seq_ok = (mem_addr_o[4:2] == 3'd0);
        end else if (mem_addr_o != last_wr + 32'd4) wr_seq_ok = 1'b0;
        last_wr = mem_addr_o;
        mon_wr++;
      end else begin
        if (mon_rd == 0) rd_seq_ok = (mem_addr_o[4:2] == 3'd0);
        else if (mem_addr_o != last_rd + 32'd4) rd_seq_ok = 1'b0;
        last_rd = mem_addr_o;
        mon_rd++;
      end
    end
  end

  // reference state
  bit         m_valid [16][8];
  bit         m_dirty [16][8];
  int         m_tag   [16][8];
  logic [6:0] m_plru  [16];
  logic [7:0] m_lock;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  function automatic logic [6:0] touch(input logic [6:0] t, input int w);
    int b2, b1, b0;
    b2 = (w >> 2) & 1; b1 = (w >> 1) & 1; b0 = w & 1;
    t[0] = (b2 == 0);
    t[1 + b2] = (b1 == 0);
    t[3 + 2 * b2 + b1] = (b0 == 0);
    return t;
  endfunction

  function automatic int pick(input int s);
    int b0, b1, b2, w;
    for (int i = 0; i < 8; i++) if (!m_valid[s][i] && !m_lock[i]) return i;
    b0 = int'(m_plru[s][0]);
    b1 = int'(m_plru[s][1 + b0]);
    b2 = int'(m_plru[s][3 + 2 * b0 + b1]);
    w = 4 * b0 + 2 * b1 + b2;
    if (!m_lock[w]) return w;
    for (int i = 0; i < 8; i++) if (!m_lock[i]) return i;
    return -1;
  endfunction

  task automatic do_req(input bit we, input bit wt, input int t, input int s, input int w,
                        input logic [31:0] d, input string lbl);
    int a, hw, v, exp_rd, exp_wr, exp_wbt, waits;
    bit hit;
    string rq;
    logic [31:0] got, expd;
    a = t * 128 + s * 8 + w;
    hw = -1;
    exp_wbt = -1;
    for (int i = 0; i < 8; i++) if (m_valid[s][i] && m_tag[s][i] == t) hw = i;
    hit = (hw >= 0);
    if (hit) begin
      exp_rd = 0;
      exp_wr = (we && wt) ? 1 : 0;
      rq = (we && wt) ? "R6" : "R3";
      m_plru[s] = touch(m_plru[s], hw);
      if (we && !wt) m_dirty[s][hw] = 1'b1;
    end else if (we && wt) begin
      exp_rd = 0; exp_wr = 1; rq = "R7";
    end else if (m_lock == 8'hFF) begin
      exp_rd = we ? 0 : 1; exp_wr = we ? 1 : 0; rq = "R9";
    end else begin
      v = pick(s);
      exp_rd = 8;
      exp_wr = m_dirty[s][v] ? 8 : 0;
      if (m_dirty[s][v]) exp_wbt = m_tag[s][v];
      rq = m_dirty[s][v] ? "R5" : (we ? "R12" : "R2");
      m_valid[s][v] = 1'b1;
      m_tag[s][v]   = t;
      m_dirty[s][v] = we;
      m_plru[s] = touch(touch(m_plru[s], v), v);
    end
    if (lbl != "") rq = lbl;
    expd = gold[a];

    @(negedge clk_i);
    mon_rd = 0; mon_wr = 0; rd_seq_ok = 1'b1; wr_seq_ok = 1'b1;
    req_valid_i = 1'b1; req_we_i = we; req_wt_i = wt;
    req_addr_i = 32'(a) << 2; req_wdata_i = d;
    waits = 0;
    #1;
    while (!req_ready_o && waits < 100) begin
      @(negedge clk_i); #1; waits++;
    end
    got = req_rdata_o;
    @(posedge clk_i); #1;
    req_valid_i = 1'b0;

    if (!we) chk(got == expd, rq, "load data", got, expd);
    chk(mon_rd == exp_rd, rq, "memory reads", 32'(mon_rd), 32'(exp_rd));
    chk(mon_wr == exp_wr, rq, "memory writes", 32'(mon_wr), 32'(exp_wr));
    if (exp_wbt >= 0) begin
      chk(first_wr == 32'((exp_wbt * 128 + s * 8) * 4), "R4 R11", "victim line address",
          first_wr, 32'((exp_wbt * 128 + s * 8) * 4));
      chk(wr_seq_ok, "R5", "writeback order", 32'(wr_seq_ok), 32'd1);
    end
    if (exp_rd == 8) chk(rd_seq_ok, "R2", "fill order", 32'(rd_seq_ok), 32'd1);
    if (hit && !(we && wt)) chk(waits == 0, "R3", "hit latency", 32'(waits), 32'd0);
    if (we) gold[a] = d;
  endtask

  task automatic set_lock(input logic [7:0] m);
    @(negedge clk_i);
    lock_we_i = 1'b1; lock_i = m;
    @(negedge clk_i);
    lock_we_i = 1'b0;
    m_lock = m;   // R8: mask applies to every set
  endtask

  task automatic do_inval();
    @(negedge clk_i);
    inval_i = 1'b1;
    @(negedge clk_i);
    inval_i = 1'b0;
    for (int s = 0; s < 16; s++) begin
      m_plru[s] = '0;
      for (int i = 0; i < 8; i++) begin m_valid[s][i] = 1'b0; m_dirty[s][i] = 1'b0; end
    end
    for (int i = 0; i < 2048; i++) gold[i] = bench_mem[i];
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int locked_t;
    for (int i = 0; i < 2048; i++) begin
      bench_mem[i] = (32'(i) * 32'h9E37_79B1) ^ 32'hA5A5_0000;
      gold[i] = bench_mem[i];
    end
    for (int s = 0; s < 16; s++) begin
      m_plru[s] = '0;
      for (int i = 0; i < 8; i++) begin m_valid[s][i] = 0; m_dirty[s][i] = 0; m_tag[s][i] = 0; end
    end
    m_lock = '0;

    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk(mem_valid_o == 1'b0, "R1", "mem_valid in reset", 32'(mem_valid_o), 32'd0);
    chk(req_ready_o == 1'b0, "R1", "ready in reset", 32'(req_ready_o), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(mem_valid_o == 1'b0, "R1", "mem_valid idle", 32'(mem_valid_o), 32'd0);

    // every set: fill all ways then one tree eviction
    for (int s = 0; s < 16; s++)
      for (int t = 0; t < 9; t++) do_req(1'b0, 1'b0, t, s, t % 8, '0, (t == 0) ? "R1" : "");
    // write-back stores: dirty lines and dirty evictions
    for (int s = 0; s < 16; s++)
      for (int t = 0; t < 11; t++)
        do_req(1'b1, 1'b0, (t * 3) % 11, s, (t + s) % 8, 32'hC000_0000 + 32'(s * 256 + t), "");
    // write-through hits and misses
    for (int s = 0; s < 16; s++)
      for (int t = 0; t < 12; t++)
        do_req(1'b1, 1'b1, t, s, (t * 5) % 8, 32'hD000_0000 + 32'(s * 256 + t), "");

    // one way locked: its line survives a stream of misses
    locked_t = m_tag[0][0];
    set_lock(8'h01);
    for (int t = 0; t < 16; t++) if (t != locked_t) do_req(1'b1, 1'b0, t, 0, t % 8, 32'(t), "");
    do_req(1'b0, 1'b0, locked_t, 0, 2, '0, "R8");
    set_lock(8'h00);

    // mixed traffic under changing masks
    r = 32'h1234_5678;
    for (int n = 0; n < 1500; n++) begin
      r ^= r << 13; r ^= r >> 17; r ^= r << 5;
      if (n % 250 == 0) begin
        case ((n / 250) % 6)
          0: set_lock(8'h00);
          1: set_lock(8'h81);
          2: set_lock(8'h7E);
          3: set_lock(8'hFE);
          4: set_lock(8'h3C);
          default: set_lock(8'h00);
        endcase
      end
      if (n == 700) do_inval();
      do_req(r[1], r[1] & r[0], int'(r[11:8]) % 12, int'(r[5:4]), int'(r[14:12]), r, "");
    end

    // all ways locked: bypass
    set_lock(8'hFF);
    for (int i = 0; i < 6; i++) do_req(1'b0, 1'b0, 13 + (i % 3), 2, i, '0, "R9");
    do_req(1'b1, 1'b0, 14, 2, 3, 32'hBEEF_0001, "R9");
    do_req(1'b0, 1'b0, 14, 2, 3, '0, "R9");
    set_lock(8'h00);

    // invalidate drops dirty data without writeback
    do_req(1'b1, 1'b0, 15, 5, 1, 32'hFACE_0000, "R12");
    do_inval();
    do_req(1'b0, 1'b0, 15, 5, 1, '0, "R10");
    do_req(1'b0, 1'b0, 15, 5, 1, '0, "R3");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule